// File: doc/BRIEF.md
# PWM Period and Duty Capture

This block measures a pulse-width-modulated signal arriving on a single input pin. The pin is synchronised into the clock domain and fed to two capture channels. Each channel has its own input-route code, edge polarity and capture enable. A 16-bit counter advances once per prescaled tick.

In the measuring setup, channel one fires on the rising edge. The same rising edge is chosen as the trigger, and the counter mode clears the counter on that trigger. Channel two fires on the falling edge. Channel one then holds the period and channel two holds the high time, both in prescaled ticks.

Each channel keeps a sticky capture flag and an overcapture flag, and each has a clear input. When the trigger or counter mode holds any other code, the counter runs freely and wraps.

Top module: `pwm_capture_top`

## Requirements
- R1: After reset every capture value, every flag and the counter output are zero.
- R2: Set up as follows: channel-one route 01, channel-one polarity (P,NP)=(0,0), trigger code 101, counter mode 100 and prescaler p. For a waveform of period T clocks, channel one then captures floor((T-1)/(p+1)). The capture and the clearing of the counter take effect on the same clock edge.
- R3: Set up with channel-two route 10 and channel-two polarity (P,NP)=(1,0). For a high time of H clocks, channel two then captures floor((H-1)/(p+1)).
- R4: While a channel's enable is 0, its capture value holds and its flag stays clear.
- R5: A capture sets the channel's flag. A clear pulse zeroes both the flag and the overcapture flag on the next edge, and the clear wins over a capture in the same cycle.
- R6: A capture while the channel's flag is already set raises the overcapture flag.
- R7: With any counter mode other than 100, or any trigger code other than 101, the counter is never cleared. Two rising-edge captures taken D clocks apart then differ by D when p=0.
- R8: The counter changes only to 0 or to its previous value plus one, and it wraps from 16'hFFFF to 0.
- R9: A channel whose route code is not its own code (01 for channel one, 10 for channel two) never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_pin | input | 1 | Asynchronous waveform input |
| psc | input | 16 | Prescaler; the counter ticks every psc+1 clocks |
| ch1_route | input | 2 | Channel-one route code (01 connects the pin) |
| ch2_route | input | 2 | Channel-two route code (10 connects the pin) |
| ch1_pol | input | 2 | Channel-one polarity {P,NP}: 00 rising, 10 falling, 11 both |
| ch2_pol | input | 2 | Channel-two polarity, same encoding |
| ch1_en | input | 1 | Channel-one capture enable |
| ch2_en | input | 1 | Channel-two capture enable |
| trig_code | input | 3 | Trigger source code (101 = channel-one edge) |
| cnt_mode | input | 3 | Counter mode code (100 = clear on trigger) |
| ch1_clr | input | 1 | Clears the channel-one flags |
| ch2_clr | input | 1 | Clears the channel-two flags |
| ch1_cap | output | 16 | Channel-one captured value |
| ch2_cap | output | 16 | Channel-two captured value |
| ch1_flag | output | 1 | Channel-one capture flag |
| ch2_flag | output | 1 | Channel-two capture flag |
| ch1_ovr | output | 1 | Channel-one overcapture flag |
| ch2_ovr | output | 1 | Channel-two overcapture flag |
| cnt_val | output | 16 | Current counter value |

## Verification
The checker watches, on every cycle, the rules that relate neighbouring states:
- the counter only steps by one or returns to zero;
- a clear always empties the flags;
- a disabled channel holds its value;
- overcapture only follows a set flag;
- in reset mode, a channel-one capture coincides with the counter returning to zero.

The measured values themselves can only be shown by the bench's scenarios. Those include the period and high-time arithmetic across prescaler settings and duty cycles, the free-running difference, the wrap at the top of the count, and disconnected routes.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;
    localparam int NUM_CH = 2;

    localparam logic [1:0] ROUTE_CH1 = 2'b01;
    localparam logic [1:0] ROUTE_CH2 = 2'b10;
    localparam logic [2:0] TRIG_CH1  = 3'b101;
    localparam logic [2:0] MODE_CLR  = 3'b100;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;
endpackage

// File: rtl/pwm_cap_edge.sv
module pwm_cap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;
    assign fall = ~st_q.sync[STAGES-1] & st_q.prev;
endmodule

// File: rtl/pwm_cap_presc.sv
module pwm_cap_presc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] pc_d, pc_q;

    assign tick = (pc_q >= div) && !restart;

    always_comb begin
        if (restart || pc_q >= div) pc_d = '0;
        else                        pc_d = pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/pwm_cap_chan.sv
module pwm_cap_chan
    import pwm_cap_pkg::*;
#(
    parameter logic [1:0] OWN_ROUTE = ROUTE_CH1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       fall,
    input  logic [1:0] route,
    input  logic [1:0] pol,
    input  logic       en,
    input  logic       clr,
    input  cnt_t       cnt,
    output logic       pol_edge,
    output cnt_t       cap,
    output logic       flag,
    output logic       ovr
);
    typedef struct packed {
        cnt_t val;
        logic flag;
        logic ovr;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        take;

    always_comb begin
        unique case (pol)
            2'b00:   pol_edge = rise;
            2'b10:   pol_edge = fall;
            2'b11:   pol_edge = rise | fall;
            default: pol_edge = 1'b0;
        endcase
    end

    assign take = pol_edge && en && (route == OWN_ROUTE);

    always_comb begin
        st_d = st_q;
        if (take) st_d.val = cnt;
        if (clr) begin
            st_d.flag = 1'b0;
            st_d.ovr  = 1'b0;
        end else if (take) begin
            st_d.flag = 1'b1;
            if (st_q.flag) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap  = st_q.val;
    assign flag = st_q.flag;
    assign ovr  = st_q.ovr;
endmodule

// File: rtl/pwm_capture_top.sv
module pwm_capture_top
    import pwm_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwm_pin,
    input  logic [15:0] psc,
    input  logic [1:0]  ch1_route,
    input  logic [1:0]  ch2_route,
    input  logic [1:0]  ch1_pol,
    input  logic [1:0]  ch2_pol,
    input  logic        ch1_en,
    input  logic        ch2_en,
    input  logic [2:0]  trig_code,
    input  logic [2:0]  cnt_mode,
    input  logic        ch1_clr,
    input  logic        ch2_clr,
    output logic [15:0] ch1_cap,
    output logic [15:0] ch2_cap,
    output logic        ch1_flag,
    output logic        ch2_flag,
    output logic        ch1_ovr,
    output logic        ch2_ovr,
    output logic [15:0] cnt_val
);
    logic rise, fall, tick, trig;

    logic [1:0] route_a [NUM_CH];
    logic [1:0] pol_a   [NUM_CH];
    logic       en_a    [NUM_CH];
    logic       clr_a   [NUM_CH];
    logic       pedge_a [NUM_CH];
    cnt_t       cap_a   [NUM_CH];
    logic       flag_a  [NUM_CH];
    logic       ovr_a   [NUM_CH];

    ctr_state_t ctr_d, ctr_q;

    assign route_a[0] = ch1_route;
    assign route_a[1] = ch2_route;
    assign pol_a[0]   = ch1_pol;
    assign pol_a[1]   = ch2_pol;
    assign en_a[0]    = ch1_en;
    assign en_a[1]    = ch2_en;
    assign clr_a[0]   = ch1_clr;
    assign clr_a[1]   = ch2_clr;

    pwm_cap_edge #(.STAGES(2)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pwm_pin),
        .rise (rise),
        .fall (fall)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [1:0] OWN = (c == 0) ? ROUTE_CH1 : ROUTE_CH2;
        pwm_cap_chan #(.OWN_ROUTE(OWN)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise),
            .fall    (fall),
            .route   (route_a[c]),
            .pol     (pol_a[c]),
            .en      (en_a[c]),
            .clr     (clr_a[c]),
            .cnt     (ctr_q.cnt),
            .pol_edge(pedge_a[c]),
            .cap     (cap_a[c]),
            .flag    (flag_a[c]),
            .ovr     (ovr_a[c])
        );
    end

    assign trig = (cnt_mode == MODE_CLR) && (trig_code == TRIG_CH1) && pedge_a[0];

    pwm_cap_presc #(.W(PSC_W)) presc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (psc),
        .restart(trig),
        .tick   (tick)
    );

    always_comb begin
        ctr_d = ctr_q;
        if (trig)      ctr_d.cnt = '0;
        else if (tick) ctr_d.cnt = ctr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign ch1_cap  = cap_a[0];
    assign ch2_cap  = cap_a[1];
    assign ch1_flag = flag_a[0];
    assign ch2_flag = flag_a[1];
    assign ch1_ovr  = ovr_a[0];
    assign ch2_ovr  = ovr_a[1];
    assign cnt_val  = ctr_q.cnt;
endmodule

// File: rtl/pwm_capture_chk.sv
module pwm_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  ch1_route,
    input logic [1:0]  ch1_pol,
    input logic        ch1_en,
    input logic        ch2_en,
    input logic [2:0]  trig_code,
    input logic [2:0]  cnt_mode,
    input logic        ch1_clr,
    input logic        ch2_clr,
    input logic [15:0] ch1_cap,
    input logic [15:0] ch2_cap,
    input logic        ch1_flag,
    input logic        ch2_flag,
    input logic        ch1_ovr,
    input logic        ch2_ovr,
    input logic [15:0] cnt_val
);
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != $past(cnt_val)) |-> (cnt_val == 16'd0 || cnt_val == $past(cnt_val) + 16'd1));

    // R5
    clr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_clr |=> (!ch1_flag && !ch1_ovr));

    // R5
    clr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch2_clr |=> (!ch2_flag && !ch2_ovr));

    // R4
    hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch1_en |=> $stable(ch1_cap));

    // R4
    hold2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch2_en |=> $stable(ch2_cap));

    // R6
    ovr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch1_ovr) |-> $past(ch1_flag));

    // R6
    ovr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch2_ovr) |-> $past(ch2_flag));

    // R2
    period_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ch1_flag) && $past(cnt_mode) == 3'b100 && $past(trig_code) == 3'b101
         && $past(ch1_route) == 2'b01 && $past(ch1_pol) == 2'b00) |-> (cnt_val == 16'd0));
endmodule

bind pwm_capture_top pwm_capture_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch1_route(ch1_route),
    .ch1_pol  (ch1_pol),
    .ch1_en   (ch1_en),
    .ch2_en   (ch2_en),
    .trig_code(trig_code),
    .cnt_mode (cnt_mode),
    .ch1_clr  (ch1_clr),
    .ch2_clr  (ch2_clr),
    .ch1_cap  (ch1_cap),
    .ch2_cap  (ch2_cap),
    .ch1_flag (ch1_flag),
    .ch2_flag (ch2_flag),
    .ch1_ovr  (ch1_ovr),
    .ch2_ovr  (ch2_ovr),
    .cnt_val  (cnt_val)
);

// File: tb/pwm_capture_tb.sv
module pwm_capture_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_pin = 1'b0;
    logic [15:0] psc = '0;
    logic [1:0]  ch1_route = 2'b01, ch2_route = 2'b10;
    logic [1:0]  ch1_pol = 2'b00, ch2_pol = 2'b10;
    logic        ch1_en = 1'b1, ch2_en = 1'b1;
    logic [2:0]  trig_code = 3'b101, cnt_mode = 3'b100;
    logic        ch1_clr = 1'b0, ch2_clr = 1'b0;
    logic [15:0] ch1_cap, ch2_cap, cnt_val;
    logic        ch1_flag, ch2_flag, ch1_ovr, ch2_ovr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_capture_top dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_pwm(input int t, input int h, input int n);
        for (int i = 0; i < n; i++) begin
            pwm_pin = 1'b1;
            repeat (h) @(negedge clk);
            pwm_pin = 1'b0;
            repeat (t - h) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic clear_flags();
        ch1_clr = 1'b1; ch2_clr = 1'b1;
        @(negedge clk);
        ch1_clr = 1'b0; ch2_clr = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cap1", ch1_cap, 0);
        check("R1 cap2", ch2_cap, 0);
        check("R1 flags", {ch1_flag, ch2_flag, ch1_ovr, ch2_ovr}, 0);
        check("R1 cnt", cnt_val, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6 sweep over prescaler, period and high time
        for (int p = 0; p < 3; p++) begin
            for (int ti = 0; ti < 3; ti++) begin
                int t;
                t = (ti == 0) ? 6 : (ti == 1) ? 9 : 13;
                for (int h = 1; h < t; h += 2) begin
                    psc = 16'(p);
                    clear_flags();
                    run_pwm(t, h, 3);
                    check("R2 period", ch1_cap, (t - 1) / (p + 1));
                    check("R3 high", ch2_cap, (h - 1) / (p + 1));
                    check("R6 ovr", {ch1_ovr, ch2_ovr}, 3);
                end
            end
        end

        // R5 clear zeroes flags
        clear_flags();
        check("R5 clear", {ch1_flag, ch1_ovr, ch2_flag, ch2_ovr}, 0);
        // R5 single capture sets flag without overcapture
        psc = '0;
        run_pwm(8, 3, 1);
        check("R5 set1", {ch1_flag, ch1_ovr}, 2);
        check("R5 set2", {ch2_flag, ch2_ovr}, 2);

        // R4 disabled channel holds
        clear_flags();
        held = ch2_cap;
        ch2_en = 1'b0;
        run_pwm(12, 7, 3);
        check("R4 hold", ch2_cap, held);
        check("R4 flag", ch2_flag, 0);
        check("R2 period still", ch1_cap, 11);
        ch2_en = 1'b1;

        // R9 wrong route code never captures
        clear_flags();
        held = ch1_cap;
        ch1_route = 2'b00;
        ch2_route = 2'b01;
        run_pwm(7, 2, 3);
        check("R9 ch1 hold", ch1_cap, held);
        check("R9 ch1 flag", ch1_flag, 0);
        check("R9 ch2 flag", ch2_flag, 0);
        ch1_route = 2'b01;
        ch2_route = 2'b10;

        // R7 free-running counter for other codes
        for (int m = 0; m < 2; m++) begin
            if (m == 0) cnt_mode = 3'b000; else begin cnt_mode = 3'b100; trig_code = 3'b001; end
            psc = '0;
            run_pwm(10, 4, 1);
            a = ch1_cap;
            run_pwm(10, 4, 1);
            check("R7 free diff", 16'(ch1_cap - a), 15);
        end

        // R8 wrap at top of count
        begin
            int guard = 0;
            while (cnt_val != 16'hFFFF && guard < 70000) begin
                @(negedge clk);
                guard++;
            end
            check("R8 at max", cnt_val, 16'hFFFF);
            @(negedge clk);
            check("R8 wrap", cnt_val, 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule